// File: doc/BRIEF.md
# Print-Head Row Address Scanner

This block selects one of thirteen row-address lines on one of two print-head channels. The 4-bit row code comes from one of two places. An internal modulo-14 up/down counter can step through the row codes in a single-bit-change order. Or, when that counter is switched off, four direct select inputs supply the code. A decoder turns the code into a single active line. A channel select picks which head receives it, and an active-low channel enable can blank both heads.

Three of the select inputs do double duty. While the internal counter is enabled, they act as counter clock, active-low counter clear and direction control. The counter clock is an ordinary data input: it is sampled in the system clock domain, and each low-to-high transition moves the counter one step. The row-address outputs are registered, so every input change reaches the outputs one system clock later. A counter step appears two system clocks after the step input rises.

Top module: `head_addr_scan`

## Requirements
- R1: With the counter enabled and direction high, each rising step moves the code through 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010, 1000 in that order (code bit 3 is the MSB).
- R2: With direction low, each rising step moves through the same list in reverse order.
- R3: Counting up from 1000 wraps to 0000. Counting down from 0000 wraps to 1000.
- R4: With the counter enabled, a low level on the clear input forces the code to 0000 and takes priority over a step.
- R5: With the counter disabled, the code is taken from the four select inputs {sel3, sel2, sel1, sel0}, and the counter holds its value.
- R6: Code number k in the R1 list (k = 1..13) activates row line k, driven on output bit k-1.
- R7: Codes 0000, 1001 and 1011 activate no row line.
- R8: Channel select low drives the line onto channel A. Channel select high drives it onto channel B. The other channel stays all zero.
- R9: When the channel enable input is high, all 26 row outputs are 0.
- R10: At most one of the 26 row outputs is 1 at any time.
- R11: A low level on rst_ni clears the counter and all row outputs.
- R12: The counter advances only on a low-to-high transition of the step input. Holding the step input high does not advance it further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | 1: internal counter supplies the code; 0: direct select |
| step_sel0_i | input | 1 | Counter step (counter mode) or code bit 0 |
| clr_sel1_i | input | 1 | Counter clear, active low (counter mode) or code bit 1 |
| dir_sel2_i | input | 1 | Up when high (counter mode) or code bit 2 |
| sel3_i | input | 1 | Code bit 3 in direct mode |
| chan_b_i | input | 1 | 0: channel A, 1: channel B |
| chan_en_ni | input | 1 | Channel enable, active low |
| row_a_o | output | 13 | Row-address enables, channel A (bit k-1 = line k) |
| row_b_o | output | 13 | Row-address enables, channel B (bit k-1 = line k) |

## Verification
The assertions assume that all inputs are synchronous to clk_i and settle between edges. They also assume the step input stays at each level for at least one system clock; a shorter pulse would be missed and would not count as a step. The bench changes inputs only on falling clock edges. It holds each step level for a full cycle and waits at least two rising edges before it compares the outputs. When it changes mode, it first lets the counter or the select inputs settle.

// File: rtl/head_addr_pkg.sv
package head_addr_pkg;
  localparam int CODE_W     = 4;
  localparam int NUM_ROWS   = 13;
  localparam int NUM_STATES = NUM_ROWS + 1;
  localparam int IDX_W      = $clog2(NUM_STATES);
  localparam int NUM_CH     = 2;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STATES - 1);

  // Scan position -> row code: reflected binary, with the last state folded to MSB-only
  function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] idx);
    logic [CODE_W-1:0] g;
    if (idx == LAST_IDX) g = {1'b1, {(CODE_W-1){1'b0}}};
    else                 g = CODE_W'(idx ^ (idx >> 1));
    return g;
  endfunction
endpackage

// File: rtl/scan_counter.sv
module scan_counter
  import head_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  logic              clr_ni,
  input  logic              up_i,
  output logic [CODE_W-1:0] code_o
);
  logic             step_q;
  logic [IDX_W-1:0] idx_q;
  logic             step_rise;

  assign step_rise = step_i & ~step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      step_q <= step_i;
      if (en_i) begin
        if (!clr_ni) begin
          idx_q <= '0;
        end else if (step_rise) begin
          if (up_i) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
          else      idx_q <= (idx_q == '0) ? LAST_IDX : idx_q - 1'b1;
        end
      end
    end
  end

  assign code_o = idx_to_code(idx_q);

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_ni) |=> (code_o == '0));
  p_bypass_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(code_o));
  p_level_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_ni && (step_i == step_q)) |=> $stable(code_o));
endmodule

// File: rtl/row_decoder.sv
module row_decoder
  import head_addr_pkg::*;
(
  input  logic [CODE_W-1:0]   code_i,
  output logic [NUM_ROWS-1:0] line_o
);
  always_comb begin
    line_o = '0;
    for (int k = 1; k <= NUM_ROWS; k++) begin
      if (idx_to_code(IDX_W'(k)) == code_i) line_o[k-1] = 1'b1;
    end
  end

  always_comb begin
    if (code_i == 4'b0000 || code_i == 4'b1001 || code_i == 4'b1011)
      p_dead_code_r7: assert (line_o == '0);
    p_single_line_r10: assert ($countones(line_o) <= 1);
  end
endmodule

// File: rtl/head_addr_scan.sv
module head_addr_scan
  import head_addr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cnt_en_i,
  input  logic                step_sel0_i,
  input  logic                clr_sel1_i,
  input  logic                dir_sel2_i,
  input  logic                sel3_i,
  input  logic                chan_b_i,
  input  logic                chan_en_ni,
  output logic [NUM_ROWS-1:0] row_a_o,
  output logic [NUM_ROWS-1:0] row_b_o
);
  logic [CODE_W-1:0]   cnt_code;
  logic [CODE_W-1:0]   code;
  logic [NUM_ROWS-1:0] line;
  logic [NUM_ROWS-1:0] row_q [NUM_CH];

  scan_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en_i),
    .step_i (step_sel0_i),
    .clr_ni (clr_sel1_i),
    .up_i   (dir_sel2_i),
    .code_o (cnt_code)
  );

  assign code = cnt_en_i ? cnt_code : {sel3_i, dir_sel2_i, clr_sel1_i, step_sel0_i};

  row_decoder u_dec (
    .code_i (code),
    .line_o (line)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q[ch] <= '0;
      else if (!chan_en_ni && (int'(chan_b_i) == ch)) row_q[ch] <= line;
      else row_q[ch] <= '0;
    end
  end

  assign row_a_o = row_q[0];
  assign row_b_o = row_q[1];

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({row_b_o, row_a_o}));
  p_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_en_ni |=> (row_a_o == '0 && row_b_o == '0));
  p_route_a_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_b_i |=> (row_b_o == '0));
  p_route_b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_b_i |=> (row_a_o == '0));
endmodule

// File: tb/tb_head_addr_scan.sv
`timescale 1ns/1ps
module tb_head_addr_scan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0, chb = 1'b0, en_n = 1'b1;
  logic [12:0] row_a, row_b;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  head_addr_scan dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .step_sel0_i(s0),
    .clr_sel1_i(s1), .dir_sel2_i(s2), .sel3_i(s3), .chan_b_i(chb),
    .chan_en_ni(en_n), .row_a_o(row_a), .row_b_o(row_b)
  );

  typedef struct packed {
    logic [3:0] code;
    logic       chb;
    logic       en_n;
    logic [3:0] line;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 1'b0, 1'b0, 4'd1},  '{4'b0011, 1'b0, 1'b0, 4'd2},
    '{4'b0010, 1'b0, 1'b0, 4'd3},  '{4'b0110, 1'b0, 1'b0, 4'd4},
    '{4'b0111, 1'b0, 1'b0, 4'd5},  '{4'b0101, 1'b0, 1'b0, 4'd6},
    '{4'b0100, 1'b0, 1'b0, 4'd7},  '{4'b1100, 1'b1, 1'b0, 4'd8},
    '{4'b1101, 1'b1, 1'b0, 4'd9},  '{4'b1111, 1'b1, 1'b0, 4'd10},
    '{4'b1110, 1'b1, 1'b0, 4'd11}, '{4'b1010, 1'b1, 1'b0, 4'd12},
    '{4'b1000, 1'b1, 1'b0, 4'd13}, '{4'b0000, 1'b0, 1'b0, 4'd0},
    '{4'b1001, 1'b0, 1'b0, 4'd0},  '{4'b1011, 1'b1, 1'b0, 4'd0},
    '{4'b0001, 1'b1, 1'b0, 4'd1},  '{4'b1000, 1'b0, 1'b0, 4'd13},
    '{4'b0110, 1'b0, 1'b1, 4'd4},  '{4'b1000, 1'b1, 1'b1, 4'd13},
    '{4'b0111, 1'b1, 1'b0, 4'd5},  '{4'b0100, 1'b0, 1'b0, 4'd7}
  };

  function automatic logic [25:0] expect_rows(input logic [3:0] line, input logic b, input logic dis);
    logic [12:0] one;
    one = (line == 0 || dis) ? 13'd0 : (13'd1 << (line - 1));
    return b ? {one, 13'd0} : {13'd0, one};
  endfunction

  task automatic check(input logic [25:0] exp, input string tag);
    n_chk++;
    if ({row_b, row_a} !== exp) begin
      n_fail++;
      $display("FAIL %s: got b=%b a=%b expected b=%b a=%b", tag, row_b, row_a, exp[25:13], exp[12:0]);
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk) s0 = 1'b1;
    @(negedge clk) s0 = 1'b0;
    settle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    settle();
    check(26'd0, "R11 reset state");
    rst_n = 1'b1;
    settle();

    // Direct select: R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {s3, s2, s1, s0} = VECS[i].code;
      chb  = VECS[i].chb;
      en_n = VECS[i].en_n;
      settle();
      check(expect_rows(VECS[i].line, VECS[i].chb, VECS[i].en_n), $sformatf("R5/R6/R7/R8/R9 vec %0d", i));
    end

    // Counter mode, up through full cycle plus wrap: R1 R3
    @(negedge clk);
    {s3, s2, s1, s0} = 4'b0110;  // dir up, clear released, step low
    chb = 1'b0; en_n = 1'b0; cnt_en = 1'b1;
    settle();
    check(26'd0, "R4 counter starts at 0000");
    for (int k = 1; k <= 14; k++) begin
      step();
      check(expect_rows(4'(k % 14), 1'b0, 1'b0), $sformatf("R1 R3 up step %0d", k));
    end

    // Down: R2 R3 (from 0000 wrap to 1000)
    @(negedge clk) s2 = 1'b0;
    for (int k = 1; k <= 14; k++) begin
      step();
      check(expect_rows(4'((14 - k) % 14), 1'b1 & 1'b0, 1'b0), $sformatf("R2 R3 down step %0d", k));
    end

    // Level hold R12: at 0000, go up, hold step high
    @(negedge clk) s2 = 1'b1;
    @(negedge clk) s0 = 1'b1;
    repeat (6) @(negedge clk);
    check(expect_rows(4'd1, 1'b0, 1'b0), "R12 held step advances once");
    @(negedge clk) s0 = 1'b0;
    step(); step();
    check(expect_rows(4'd3, 1'b0, 1'b0), "R12 two more edges");

    // Counter on channel B
    @(negedge clk) chb = 1'b1;
    settle();
    check(expect_rows(4'd3, 1'b1, 1'b0), "R8 counter on channel B");

    // Bypass holds counter: R5
    @(negedge clk) cnt_en = 1'b0; {s3, s2, s1, s0} = 4'b1000;
    settle();
    check(expect_rows(4'd13, 1'b1, 1'b0), "R5 bypass uses selects");
    @(negedge clk) s0 = 1'b1;
    @(negedge clk) s0 = 1'b0;
    @(negedge clk) s0 = 1'b1;
    @(negedge clk) {s3, s2, s1, s0} = 4'b0110; cnt_en = 1'b1;
    settle();
    check(expect_rows(4'd3, 1'b1, 1'b0), "R5 counter held while bypassed");

    // Clear priority over step: R4
    @(negedge clk) s1 = 1'b0; s0 = 1'b1;
    settle();
    check(26'd0, "R4 clear forces 0000");
    @(negedge clk) s0 = 1'b0; s1 = 1'b1;
    step();
    check(expect_rows(4'd1, 1'b1, 1'b0), "R4 count resumes from 0000");

    // Global reset mid-run: R11
    step();
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(26'd0, "R11 async reset clears outputs");
    @(negedge clk) rst_n = 1'b1;
    settle();
    check(26'd0, "R11 counter cleared by reset");

    done = 1;
    finish_run();
  end
endmodule